// File: doc/BRIEF.md
# Cycle-Stealing Byte DMA Engine

This block moves a block of bytes between one I/O device and memory without the processor copying each byte. The processor first writes four settings: the memory start address, the number of bytes, the device address, and the direction. It then writes a go bit. After that, the device asks for each byte with a request line. For each request the engine raises a bus request to the bus arbiter, waits for the grant, and uses the memory bus for exactly one cycle. It then gives the bus back and acknowledges the device.

After each byte the engine moves its memory pointer up by one and its remaining count down by one. It does not interrupt the processor per byte. It raises one level interrupt when the remaining count reaches zero. That interrupt stays high until the processor clears it, and a new transfer cannot start while it is pending.

Top module: `dma_cycle_steal`

## Requirements
- R1: After reset, `irq`, `busReq`, `devAck`, `memWe` and `memRe` are all low, and the engine is idle and not armed.
- R2: A control write (`regSel`=0) with bit 0 set arms the engine only if the byte count is non-zero and no interrupt is pending. Otherwise the go bit is refused, and later device requests get no acknowledge. Bit 1 of the same write selects the direction: 0 moves device to memory, 1 moves memory to device. Selects 1, 2 and 3 load the memory address, byte count and device address.
- R3: While the engine is armed, writes to the address, count, device-address and direction settings are ignored. The transfer in progress keeps using its original pointer.
- R4: A device request on an armed engine raises `busReq`. `memWe` or `memRe` is driven only in a cycle where both `busReq` and `busGrant` are high.
- R5: Each byte takes exactly one bus cycle. In the cycle after the memory access, `busReq` is low and `devAck` is high.
- R6: For device to memory, the engine latches `devDataIn` when the grant arrives and writes that byte to memory. For memory to device, the engine latches the memory byte during the bus cycle and shows it on `devDataOut` while `devAck` is high.
- R7: After each byte, `memAddr` is one higher than the address used for the access, and the remaining count is one lower.
- R8: `irq` rises only in the cycle of the final acknowledge, when the count reaches zero, and never after earlier bytes. It stays high until a control write with bit 2 set, and falls only after such a write.
- R9: A device request while the engine is not armed (count exhausted, or never started) gets no `busReq` and no `devAck`.
- R10: `devAck` is high for a single cycle per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Processor setting write strobe |
| regSel | input | 2 | Setting select: 0 control, 1 memory address, 2 byte count, 3 device address |
| regWdata | input | REG_W | Setting write data; control bits are 0 go, 1 direction, 2 clear interrupt |
| devReq | input | 1 | Device asks for one byte transfer |
| devAck | output | 1 | One-cycle acknowledge to the device |
| devDataIn | input | DATA_W | Byte from the device |
| devDataOut | output | DATA_W | Byte to the device (held data register) |
| devAddrOut | output | DEV_W | Programmed device address |
| busReq | output | 1 | Request for the memory bus |
| busGrant | input | 1 | Bus granted by the arbiter |
| memAddr | output | ADDR_W | Current memory pointer |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| memWdata | output | DATA_W | Byte written to memory |
| memRdata | input | DATA_W | Byte read from memory, valid in the read cycle |
| irq | output | 1 | Completion interrupt, level |

## Verification
The device-to-memory run uses three distinct bytes with grant delays of zero, one and two cycles. Each byte must land at its own address, and the engine must hold the bus for one cycle however long the grant took. This separates a correct pointer update from a stuck or doubled one. The memory-to-device run reads preloaded bytes, and an address write lands between its bytes. This separates a latched read path and a locked pointer from a live one. Requests are also made after completion, after a refused go (interrupt pending, or count zero) and before any go. These must stay unanswered, which separates the arming rules from an engine that answers every request.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_ACK  = 2'd3
  } dmaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchDev;   // capture device byte into data register
    logic latchMem;   // capture memory byte into data register
    logic advance;    // pointer up, count down
  } dpStrobe_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_DEV  = 2'd3;

  localparam int BIT_GO  = 0;
  localparam int BIT_DIR = 1;
  localparam int BIT_CLR = 2;

endpackage

// File: rtl/dma_cs_datapath.sv
module dma_cs_datapath
  import dma_cs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEV_W  = 8,
  parameter int DATA_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              lock,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] devDataIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DEV_W-1:0]  devAddr,
  output logic [DATA_W-1:0] dataReg,
  output logic              dirRead,
  output logic              countZero,
  output logic              countOne,
  output logic              cmdGo,
  output logic              cmdClr
);

  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [CNT_W-1:0] countReg;
  logic             ctrlWrite;
  logic             cfgOpen;

  assign ctrlWrite = regWe && (regSel == SEL_CTRL);
  assign cfgOpen   = regWe && !lock;
  assign cmdGo     = ctrlWrite && regWdata[BIT_GO];
  assign cmdClr    = ctrlWrite && regWdata[BIT_CLR];
  assign countZero = (countReg == '0);
  assign countOne  = (countReg == CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      countReg <= '0;
      devAddr  <= '0;
      dirRead  <= 1'b0;
    end else if (strobe.advance) begin
      memAddr  <= memAddr + ADDR_ONE;
      countReg <= countReg - CNT_ONE;
    end else if (cfgOpen) begin
      case (regSel)
        SEL_CTRL: dirRead  <= regWdata[BIT_DIR];
        SEL_ADDR: memAddr  <= regWdata[ADDR_W-1:0];
        SEL_CNT:  countReg <= regWdata[CNT_W-1:0];
        default:  devAddr  <= regWdata[DEV_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strobe.latchDev) begin
      dataReg <= devDataIn;
    end else if (strobe.latchMem) begin
      dataReg <= memRdata;
    end
  end

endmodule

// File: rtl/dma_cs_ctrl.sv
module dma_cs_ctrl
  import dma_cs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      devReq,
  input  logic      busGrant,
  input  logic      cmdGo,
  input  logic      cmdClr,
  input  logic      dirRead,
  input  logic      countZero,
  input  logic      countOne,
  output dpStrobe_t strobe,
  output logic      armed,
  output logic      busReq,
  output logic      memWe,
  output logic      memRe,
  output logic      devAck,
  output logic      irq
);

  dmaState_e state, stateNext;
  logic      finalByte;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (armed && devReq) stateNext = ST_WAIT;
      ST_WAIT: if (busGrant)        stateNext = ST_XFER;
      ST_XFER:                      stateNext = ST_ACK;
      default:                      stateNext = ST_IDLE;
    endcase
  end

  assign busReq = (state == ST_WAIT) || (state == ST_XFER);
  assign memWe  = (state == ST_XFER) && !dirRead;
  assign memRe  = (state == ST_XFER) && dirRead;
  assign devAck = (state == ST_ACK);

  always_comb begin
    strobe          = '0;
    strobe.latchDev = (state == ST_WAIT) && busGrant && !dirRead;
    strobe.latchMem = (state == ST_XFER) && dirRead;
    strobe.advance  = (state == ST_XFER);
  end

  assign finalByte = (state == ST_XFER) && countOne;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      armed <= 1'b0;
      irq   <= 1'b0;
    end else begin
      state <= stateNext;
      if (finalByte) begin
        armed <= 1'b0;
        irq   <= 1'b1;
      end else begin
        if (cmdGo && !armed && !irq && !countZero) armed <= 1'b1;
        if (cmdClr) irq <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma_cycle_steal.sv
module dma_cycle_steal
  import dma_cs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEV_W  = 8,
  parameter int DATA_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              devReq,
  output logic              devAck,
  input  logic [DATA_W-1:0] devDataIn,
  output logic [DATA_W-1:0] devDataOut,
  output logic [DEV_W-1:0]  devAddrOut,
  output logic              busReq,
  input  logic              busGrant,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              irq
);

  dpStrobe_t         strobe;
  logic              armed;
  logic              dirRead;
  logic              countZero;
  logic              countOne;
  logic              cmdGo;
  logic              cmdClr;
  logic [DATA_W-1:0] dataReg;

  dma_cs_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W),
    .DATA_W(DATA_W), .REG_W(REG_W)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .lock(armed), .strobe(strobe),
    .devDataIn(devDataIn), .memRdata(memRdata),
    .memAddr(memAddr), .devAddr(devAddrOut), .dataReg(dataReg),
    .dirRead(dirRead), .countZero(countZero), .countOne(countOne),
    .cmdGo(cmdGo), .cmdClr(cmdClr)
  );

  dma_cs_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .devReq(devReq), .busGrant(busGrant),
    .cmdGo(cmdGo), .cmdClr(cmdClr), .dirRead(dirRead),
    .countZero(countZero), .countOne(countOne),
    .strobe(strobe), .armed(armed),
    .busReq(busReq), .memWe(memWe), .memRe(memRe),
    .devAck(devAck), .irq(irq)
  );

  assign devDataOut = dataReg;
  assign memWdata   = dataReg;

endmodule

// File: rtl/dma_cs_checker.sv
module dma_cs_checker #(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [1:0]        regSel,
  input logic [REG_W-1:0]  regWdata,
  input logic              devAck,
  input logic              busReq,
  input logic              busGrant,
  input logic              memWe,
  input logic              memRe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              irq
);

  assert_bus_owned_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> (busReq && busGrant));

  assert_no_dual_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  assert_single_steal_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |=> (devAck && !busReq));

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    devAck |-> (memAddr == ADDR_W'($past(memAddr) + 1'b1)));

  assert_irq_on_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> devAck);

  assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(regWe && (regSel == 2'd0) && regWdata[2]));

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    devAck |=> !devAck);

endmodule

bind dma_cycle_steal dma_cs_checker #(.ADDR_W(ADDR_W), .REG_W(REG_W)) uChk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
  .devAck(devAck), .busReq(busReq), .busGrant(busGrant),
  .memWe(memWe), .memRe(memRe), .memAddr(memAddr), .irq(irq)
);

// File: tb/tb_dma_cycle_steal.sv
module tb_dma_cycle_steal;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [1:0]  regSel;
  logic [15:0] regWdata;
  logic        devReq;
  logic        devAck;
  logic [7:0]  devDataIn;
  logic [7:0]  devDataOut;
  logic [7:0]  devAddrOut;
  logic        busReq;
  logic        busGrant;
  logic [15:0] memAddr;
  logic        memWe;
  logic        memRe;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata;
  logic        irq;

  logic [7:0] mem [256];
  int total = 0;
  int bad = 0;

  logic       gotAck;
  logic [7:0] ackData;
  int         stolen;
  logic       irqAtAck;

  always #2 clk = ~clk;

  dma_cycle_steal dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .devReq(devReq), .devAck(devAck), .devDataIn(devDataIn), .devDataOut(devDataOut),
    .devAddrOut(devAddrOut), .busReq(busReq), .busGrant(busGrant),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .memWdata(memWdata),
    .memRdata(memRdata), .irq(irq)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // one device request; the bench plays memory and arbiter
  task automatic moveByte(input logic [7:0] d, input int grantDelay);
    int waitCnt = 0;
    logic done = 1'b0;
    gotAck = 1'b0; ackData = '0; stolen = 0; irqAtAck = 1'b0;
    @(negedge clk);
    devReq = 1'b1; devDataIn = d;
    for (int i = 0; i < 40 && !done; i++) begin
      @(negedge clk);
      if (busReq && busGrant) stolen++;
      if (memWe) mem[memAddr[7:0]] = memWdata;
      memRdata = mem[memAddr[7:0]];
      if (busReq) begin
        waitCnt++;
        busGrant = (waitCnt > grantDelay);
      end else begin
        busGrant = 1'b0;
      end
      if (devAck) begin
        gotAck = 1'b1; ackData = devDataOut; irqAtAck = irq;
        devReq = 1'b0; done = 1'b1;
      end
    end
    devReq = 1'b0; busGrant = 1'b0;
  endtask

  task automatic probeNoAck(input string req);
    int seen = 0;
    @(negedge clk);
    devReq = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (devAck || busReq) seen++;
    end
    devReq = 1'b0;
    check(seen == 0, req, seen, 0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check({irq, busReq, devAck, memWe, memRe} == 5'b0, "R1 outputs idle in reset",
          {irq, busReq, devAck, memWe, memRe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({irq, busReq, devAck} == 3'b0, "R1 outputs idle after reset",
          {irq, busReq, devAck}, 0);
  endtask

  task automatic testDevToMem();
    logic [7:0] bytesIn [3];
    bytesIn[0] = 8'hA1; bytesIn[1] = 8'hB2; bytesIn[2] = 8'hC3;
    regWrite(2'd1, 16'h0040);
    regWrite(2'd2, 16'd3);
    regWrite(2'd3, 16'h0005);
    regWrite(2'd0, 16'h0001);
    check(devAddrOut == 8'h05, "R2 device address loaded", devAddrOut, 5);
    for (int b = 0; b < 3; b++) begin
      moveByte(bytesIn[b], b);
      check(gotAck, "R4 request acknowledged", gotAck, 1);
      check(stolen == 1, "R5 one bus cycle per byte", stolen, 1);
      check(irqAtAck == (b == 2), "R8 irq only on final byte", irqAtAck, (b == 2));
    end
    for (int b = 0; b < 3; b++)
      check(mem[8'h40 + b] == bytesIn[b], "R6 device byte written to memory",
            mem[8'h40 + b], bytesIn[b]);
    check(memAddr == 16'h0043, "R7 pointer advanced per byte", memAddr, 16'h43);
  endtask

  task automatic testIrqHeld();
    repeat (5) @(negedge clk);
    check(irq, "R8 irq holds until clear", irq, 1);
    probeNoAck("R9 request after count exhausted ignored");
  endtask

  task automatic testRefusedGo();
    mem[8'h60] = 8'h11; mem[8'h61] = 8'h22;
    regWrite(2'd1, 16'h0060);
    regWrite(2'd2, 16'd2);
    regWrite(2'd0, 16'h0003);
    probeNoAck("R2 go refused while irq pending");
    regWrite(2'd0, 16'h0004);
    check(!irq, "R8 irq cleared by clear bit", irq, 0);
    probeNoAck("R9 request before go ignored");
    regWrite(2'd0, 16'h0003);
    moveByte(8'h00, 1);
    check(gotAck && ackData == 8'h11, "R6 memory byte shown at ack", ackData, 8'h11);
    check(stolen == 1, "R5 one bus cycle on read", stolen, 1);
    regWrite(2'd1, 16'h0010);
    check(memAddr == 16'h0061, "R3 address write ignored while armed", memAddr, 16'h61);
    moveByte(8'h00, 0);
    check(gotAck && ackData == 8'h22, "R3 second byte from original pointer", ackData, 8'h22);
    check(irqAtAck, "R8 irq on final read byte", irqAtAck, 1);
    regWrite(2'd0, 16'h0004);
  endtask

  task automatic testZeroCount();
    regWrite(2'd2, 16'd0);
    regWrite(2'd0, 16'h0001);
    probeNoAck("R2 go refused with zero count");
    check(!irq && memAddr == 16'h0062, "R9 no side effect on pointer or irq", memAddr, 16'h62);
  endtask

  initial begin
    rstN = 1'b0; regWe = 1'b0; regSel = '0; regWdata = '0;
    devReq = 1'b0; devDataIn = '0; busGrant = 1'b0; memRdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    testReset();
    testDevToMem();
    testIrqHeld();
    testRefusedGo();
    testZeroCount();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule